// File: doc/BRIEF.md
# Timing-Accurate Simulation Channel

This block is a one-way, point-to-point link between one sending unit and one receiving unit of an emulated machine. The emulation runs on a fast host clock, while each unit keeps its own count of simulated (target) cycles. For every target cycle the sender hands the channel exactly one fragment: either a data fragment (live bit 1 with a payload) or an idle fragment (live bit 0). Idles are stored like data, so the passage of simulated time reaches the receiver even when nothing is being sent. The receiver therefore counts target cycles exactly, whatever stalls the host side adds.

Both sides use valid/ready handshakes on the host clock. Each accepted handshake is one target cycle on that side, and the block shows a target-cycle counter for each side. After reset the channel loads itself with `LAT_CYC` idle fragments. A fragment accepted in sender target cycle t is therefore delivered in receiver target cycle t + `LAT_CYC`. The buffer holds `DEPTH` fragments, which must be at least `LAT_CYC` + 1. When it is full, the sender is back-pressured, and that stalls the sender's target clock.

Control is a four-state machine. ST_FILL writes one idle fragment per host cycle until `LAT_CYC` are stored, then moves to ST_MID. If `LAT_CYC` is 0, reset enters ST_EMPTY directly. ST_EMPTY, ST_MID and ST_FULL track occupancy. After each cycle's writes and reads, the next state is ST_EMPTY when the buffer holds no fragments, ST_FULL when it holds `DEPTH` fragments, and ST_MID for any other count. Every move between these three states follows that rule.

Top module: `sim_link_channel`

## Requirements
- R1: While reset is asserted and in the first host cycle after it is released, both target-cycle counters read 0 and `rcv_valid` is 0. With `LAT_CYC` > 0, `snd_ready` is also 0 in that cycle.
- R2: `LAT_CYC` host cycles after reset is released, `snd_ready` and `rcv_valid` are both 1. The first `LAT_CYC` fragments the receiver takes are idle (`rcv_live` = 0).
- R3: Fragments reach the receiver in the order they were accepted, with none dropped or duplicated. Once the channel is fully drained, `rcv_tcyc` equals `snd_tcyc` + `LAT_CYC`.
- R4: A fragment accepted while `snd_tcyc` = t is delivered while `rcv_tcyc` = t + `LAT_CYC`.
- R5: An idle fragment reaches the receiver with `rcv_data` all zero, whatever payload was offered with it.
- R6: When `DEPTH` fragments are held, `snd_ready` is 0. If the channel starts empty and the receiver is stalled, exactly `DEPTH` sender handshakes complete.
- R7: `rcv_valid` is 0 when the channel is empty (no bypass). A fragment written into an empty channel is offered in the next host cycle.
- R8: Each side's target-cycle counter rises by exactly 1 on each of its handshakes, for data and idle fragments alike, and holds otherwise.
- R9: A send and a receive in the same host cycle both complete, and both counters advance by one.
- R10: While `rcv_valid` is 1 and `rcv_ready` is 0, the offered fragment (`rcv_live`, `rcv_data`) and `rcv_valid` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | 1 | Sender offers its fragment for the current target cycle |
| snd_live | input | 1 | 1 = data fragment, 0 = idle fragment |
| snd_data | input | DATA_W | Sender payload |
| snd_ready | output | 1 | Channel accepts a fragment this host cycle |
| snd_tcyc | output | TCYC_W | Sender target-cycle count |
| rcv_valid | output | 1 | A fragment is offered to the receiver |
| rcv_live | output | 1 | Offered fragment is data (1) or idle (0) |
| rcv_data | output | DATA_W | Offered payload, zero for idles |
| rcv_ready | input | 1 | Receiver takes the offered fragment |
| rcv_tcyc | output | TCYC_W | Receiver target-cycle count |

## Verification
A write and a read can land in the same host cycle, and how they interact depends on the state. In ST_MID both must complete and occupancy must stay the same. In ST_FULL only the read completes. In ST_EMPTY only the write completes. The bench provokes ST_MID by filling the channel, releasing one entry and then firing both handshakes at once. It judges the result through both counters and through `snd_ready`/`rcv_valid` afterwards. A long random stream then mixes stalls on both sides into all three states. Every fragment taken is compared with the fragment the sender gave `LAT_CYC` target cycles earlier.

// File: rtl/sim_chan_pkg.sv
package sim_chan_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_EMPTY = 2'd1,
        ST_MID   = 2'd2,
        ST_FULL  = 2'd3
    } chan_state_e;

endpackage

// File: rtl/sim_chan_tcount.sv
module sim_chan_tcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (step_i) begin
            count_o <= count_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sim_chan_store.sv
module sim_chan_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 6,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_ptr_i,
    input  logic              wr_live_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_ptr_i,
    output logic              rd_live_o,
    output logic [DATA_W-1:0] rd_data_o
);

    logic              ent_live [DEPTH];
    logic [DATA_W-1:0] ent_data [DEPTH];

    // One register slot per fragment; idle payloads are stored as zero.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_live[gi] <= 1'b0;
                ent_data[gi] <= '0;
            end else if (wr_en_i && (wr_ptr_i == PTR_W'(gi))) begin
                ent_live[gi] <= wr_live_i;
                ent_data[gi] <= wr_live_i ? wr_data_i : '0;
            end
        end
    end

    assign rd_live_o = ent_live[rd_ptr_i];
    assign rd_data_o = ent_data[rd_ptr_i];

endmodule

// File: rtl/sim_chan_ctrl.sv
module sim_chan_ctrl
    import sim_chan_pkg::*;
#(
    parameter int DEPTH   = 6,
    parameter int LAT_CYC = 3,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snd_valid_i,
    input  logic             rcv_ready_i,
    output logic             snd_ready_o,
    output logic             rcv_valid_o,
    output logic             wr_en_o,
    output logic             wr_idle_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o
);

    localparam int OCC_W     = $clog2(DEPTH + 1);
    localparam int FC_W      = (LAT_CYC > 1) ? $clog2(LAT_CYC) : 1;
    localparam int FILL_LAST = (LAT_CYC > 0) ? LAT_CYC - 1 : 0;
    localparam chan_state_e RST_ST = (LAT_CYC == 0) ? ST_EMPTY : ST_FILL;

    if (DEPTH < LAT_CYC + 1) begin : g_bad_depth
        $error("DEPTH must be at least LAT_CYC + 1");
    end

    chan_state_e      state, state_nxt;
    logic [OCC_W-1:0] occ, occ_nxt;
    logic [FC_W-1:0]  fill_cnt;
    logic             pop;
    chan_state_e      occ_state;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RST_ST;
        end else begin
            state <= state_nxt;
        end
    end

    // Occupancy, pointers and preload counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ      <= '0;
            wr_ptr_o <= '0;
            rd_ptr_o <= '0;
            fill_cnt <= '0;
        end else begin
            occ <= occ_nxt;
            if (wr_en_o) begin
                wr_ptr_o <= (wr_ptr_o == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_o + PTR_W'(1);
            end
            if (pop) begin
                rd_ptr_o <= (rd_ptr_o == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_o + PTR_W'(1);
            end
            if (state == ST_FILL) begin
                fill_cnt <= fill_cnt + FC_W'(1);
            end
        end
    end

    // Outputs per state.
    always_comb begin
        snd_ready_o = 1'b0;
        rcv_valid_o = 1'b0;
        wr_idle_o   = 1'b0;
        unique case (state)
            ST_FILL: begin
                wr_idle_o = 1'b1;
            end
            ST_EMPTY: begin
                snd_ready_o = 1'b1;
            end
            ST_MID: begin
                snd_ready_o = 1'b1;
                rcv_valid_o = 1'b1;
            end
            ST_FULL: begin
                rcv_valid_o = 1'b1;
            end
        endcase
        wr_en_o = wr_idle_o || (snd_valid_i && snd_ready_o);
        pop     = rcv_valid_o && rcv_ready_i;
    end

    // Next occupancy and next state.
    always_comb begin
        occ_nxt = occ + OCC_W'(wr_en_o) - OCC_W'(pop);
        if (occ_nxt == '0) begin
            occ_state = ST_EMPTY;
        end else if (occ_nxt == OCC_W'(DEPTH)) begin
            occ_state = ST_FULL;
        end else begin
            occ_state = ST_MID;
        end
        unique case (state)
            ST_FILL:  state_nxt = (fill_cnt == FC_W'(FILL_LAST)) ? ST_MID : ST_FILL;
            ST_EMPTY: state_nxt = occ_state;
            ST_MID:   state_nxt = occ_state;
            ST_FULL:  state_nxt = occ_state;
        endcase
    end

endmodule

// File: rtl/sim_link_channel.sv
module sim_link_channel #(
    parameter int DATA_W  = 8,
    parameter int LAT_CYC = 3,
    parameter int DEPTH   = 6,
    parameter int TCYC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_valid,
    input  logic              snd_live,
    input  logic [DATA_W-1:0] snd_data,
    output logic              snd_ready,
    output logic [TCYC_W-1:0] snd_tcyc,
    output logic              rcv_valid,
    output logic              rcv_live,
    output logic [DATA_W-1:0] rcv_data,
    input  logic              rcv_ready,
    output logic [TCYC_W-1:0] rcv_tcyc
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             wr_en, wr_idle, wr_live;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign wr_live = wr_idle ? 1'b0 : snd_live;

    sim_chan_ctrl #(
        .DEPTH   (DEPTH),
        .LAT_CYC (LAT_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .snd_valid_i (snd_valid),
        .rcv_ready_i (rcv_ready),
        .snd_ready_o (snd_ready),
        .rcv_valid_o (rcv_valid),
        .wr_en_o     (wr_en),
        .wr_idle_o   (wr_idle),
        .wr_ptr_o    (wr_ptr),
        .rd_ptr_o    (rd_ptr)
    );

    sim_chan_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_ptr_i  (wr_ptr),
        .wr_live_i (wr_live),
        .wr_data_i (snd_data),
        .rd_ptr_i  (rd_ptr),
        .rd_live_o (rcv_live),
        .rd_data_o (rcv_data)
    );

    sim_chan_tcount #(.CNT_W(TCYC_W)) u_snd_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (snd_valid && snd_ready),
        .count_o (snd_tcyc)
    );

    sim_chan_tcount #(.CNT_W(TCYC_W)) u_rcv_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (rcv_valid && rcv_ready),
        .count_o (rcv_tcyc)
    );

endmodule

// File: rtl/sim_link_channel_chk.sv
module sim_link_channel_chk #(
    parameter int DATA_W  = 8,
    parameter int LAT_CYC = 3,
    parameter int DEPTH   = 6,
    parameter int TCYC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snd_valid,
    input logic              snd_ready,
    input logic [TCYC_W-1:0] snd_tcyc,
    input logic              rcv_valid,
    input logic              rcv_ready,
    input logic              rcv_live,
    input logic [DATA_W-1:0] rcv_data,
    input logic [TCYC_W-1:0] rcv_tcyc
);

    // Fragments in flight, seen purely from the two counters.
    logic [TCYC_W-1:0] held;
    assign held = snd_tcyc + TCYC_W'(LAT_CYC) - rcv_tcyc;

    a_r8_snd_step: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && snd_ready) |=> (snd_tcyc == $past(snd_tcyc) + TCYC_W'(1)));

    a_r8_rcv_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_valid && rcv_ready) |=> (rcv_tcyc == $past(rcv_tcyc) + TCYC_W'(1)));

    a_r10_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_valid && !rcv_ready) |=> (rcv_valid && $stable(rcv_live) && $stable(rcv_data)));

    a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        held <= TCYC_W'(DEPTH));

    a_r6_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (held == TCYC_W'(DEPTH)) |-> !snd_ready);

    a_r7_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (held == '0) |-> !rcv_valid);

endmodule

bind sim_link_channel sim_link_channel_chk #(
    .DATA_W  (DATA_W),
    .LAT_CYC (LAT_CYC),
    .DEPTH   (DEPTH),
    .TCYC_W  (TCYC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .snd_valid (snd_valid),
    .snd_ready (snd_ready),
    .snd_tcyc  (snd_tcyc),
    .rcv_valid (rcv_valid),
    .rcv_ready (rcv_ready),
    .rcv_live  (rcv_live),
    .rcv_data  (rcv_data),
    .rcv_tcyc  (rcv_tcyc)
);

// File: tb/sim_link_channel_tb_top.sv
module sim_link_channel_tb_top;

    localparam int DW  = 8;
    localparam int LAT = 3;
    localparam int DEP = 6;
    localparam int TW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snd_valid = 1'b0, snd_live = 1'b0, rcv_ready = 1'b0;
    logic [DW-1:0] snd_data = '0;
    logic          snd_ready, rcv_valid, rcv_live;
    logic [DW-1:0] rcv_data;
    logic [TW-1:0] snd_tcyc, rcv_tcyc;

    int n_chk = 0, n_bad = 0;
    int snd_k = 0, rcv_k = 0;
    logic          exp_live [1024];
    logic [DW-1:0] exp_data [1024];

    always #5 clk = ~clk;

    sim_link_channel #(.DATA_W(DW), .LAT_CYC(LAT), .DEPTH(DEP), .TCYC_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .snd_valid(snd_valid), .snd_live(snd_live), .snd_data(snd_data),
        .snd_ready(snd_ready), .snd_tcyc(snd_tcyc),
        .rcv_valid(rcv_valid), .rcv_live(rcv_live), .rcv_data(rcv_data),
        .rcv_ready(rcv_ready), .rcv_tcyc(rcv_tcyc)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // One host cycle: drive at negedge, check handshakes, release after the edge.
    task automatic step(input logic sv, input logic sl, input logic [DW-1:0] sd,
                        input logic rr, output logic s_fire, output logic r_fire);
        @(negedge clk);
        snd_valid = sv; snd_live = sl; snd_data = sd; rcv_ready = rr;
        #1;
        s_fire = sv && snd_ready;
        r_fire = rr && rcv_valid;
        if (s_fire) begin
            chk(snd_tcyc == TW'(snd_k), "R8", "sender count at handshake", int'(snd_tcyc), snd_k);
            exp_live[snd_k] = sl;
            exp_data[snd_k] = sl ? sd : '0;
            snd_k++;
        end
        if (r_fire) begin
            chk(rcv_tcyc == TW'(rcv_k), "R4", "receiver count at delivery", int'(rcv_tcyc), rcv_k);
            if (rcv_k < LAT) begin
                chk(rcv_live == 1'b0, "R2", "preloaded fragment live bit", int'(rcv_live), 0);
            end else begin
                chk(rcv_live == exp_live[rcv_k-LAT], "R3", "live bit order",
                    int'(rcv_live), int'(exp_live[rcv_k-LAT]));
                chk(rcv_data == exp_data[rcv_k-LAT], "R3", "payload order / R5 idle zero",
                    int'(rcv_data), int'(exp_data[rcv_k-LAT]));
            end
            rcv_k++;
        end
        @(posedge clk);
        #1;
        snd_valid = 1'b0; rcv_ready = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(snd_tcyc == '0, "R1", "sender count after reset", int'(snd_tcyc), 0);
        chk(rcv_tcyc == '0, "R1", "receiver count after reset", int'(rcv_tcyc), 0);
        chk(rcv_valid == 1'b0, "R1", "rcv_valid during preload", int'(rcv_valid), 0);
        chk(snd_ready == 1'b0, "R1", "snd_ready during preload", int'(snd_ready), 0);
        repeat (LAT) @(negedge clk);
        chk(snd_ready == 1'b1, "R2", "snd_ready after preload", int'(snd_ready), 1);
        chk(rcv_valid == 1'b1, "R2", "rcv_valid after preload", int'(rcv_valid), 1);
    endtask

    task automatic t_preload();
        logic sf, rf;
        for (int i = 0; i < LAT; i++) step(1'b0, 1'b0, '0, 1'b1, sf, rf);
        @(negedge clk);
        chk(rcv_valid == 1'b0, "R7", "empty channel offers nothing", int'(rcv_valid), 0);
    endtask

    task automatic t_bypass();
        logic sf, rf;
        step(1'b1, 1'b1, 8'h3C, 1'b0, sf, rf);
        chk(sf == 1'b1, "R7", "accept into empty", int'(sf), 1);
        @(negedge clk);
        chk(rcv_valid == 1'b1, "R7", "offered next host cycle", int'(rcv_valid), 1);
        step(1'b0, 1'b0, '0, 1'b1, sf, rf);
    endtask

    task automatic t_idle_payload();
        logic sf, rf;
        step(1'b1, 1'b0, 8'hA5, 1'b0, sf, rf);
        @(negedge clk);
        chk(rcv_data == '0, "R5", "idle payload zeroed", int'(rcv_data), 0);
        chk(rcv_live == 1'b0, "R5", "idle live bit", int'(rcv_live), 0);
        step(1'b0, 1'b0, '0, 1'b1, sf, rf);
    endtask

    task automatic t_backpressure();
        logic sf, rf;
        int acc = 0;
        logic [DW-1:0] first;
        for (int i = 0; i < DEP + 2; i++) begin
            step(1'b1, 1'b1, DW'(8'h40 + i), 1'b0, sf, rf);
            if (sf) acc++;
        end
        chk(acc == DEP, "R6", "accepts before stall", acc, DEP);
        @(negedge clk);
        chk(snd_ready == 1'b0, "R6", "snd_ready when full", int'(snd_ready), 0);
        first = rcv_data;
        repeat (3) @(negedge clk);
        chk(rcv_valid == 1'b1 && rcv_data == first, "R10", "stalled offer held",
            int'(rcv_data), int'(first));
    endtask

    task automatic t_concurrent();
        logic sf, rf;
        logic [TW-1:0] s0, r0;
        step(1'b0, 1'b0, '0, 1'b1, sf, rf);
        @(negedge clk);
        s0 = snd_tcyc; r0 = rcv_tcyc;
        step(1'b1, 1'b1, 8'h77, 1'b1, sf, rf);
        chk(sf && rf, "R9", "both handshakes fire", int'({sf, rf}), 3);
        @(negedge clk);
        chk(snd_tcyc == s0 + TW'(1), "R9", "sender count advanced", int'(snd_tcyc), int'(s0) + 1);
        chk(rcv_tcyc == r0 + TW'(1), "R9", "receiver count advanced", int'(rcv_tcyc), int'(r0) + 1);
        chk(snd_ready && rcv_valid, "R9", "occupancy unchanged", int'({snd_ready, rcv_valid}), 3);
    endtask

    task automatic t_stream();
        logic sf, rf;
        for (int i = 0; i < 400; i++) begin
            step(1'($urandom % 4 != 0), 1'($urandom % 2), DW'($urandom), 1'($urandom % 3 != 0), sf, rf);
        end
    endtask

    task automatic t_drain();
        logic sf, rf;
        for (int i = 0; i < 2 * DEP; i++) begin
            @(negedge clk);
            if (rcv_valid) step(1'b0, 1'b0, '0, 1'b1, sf, rf);
        end
        @(negedge clk);
        chk(rcv_valid == 1'b0, "R3", "drained", int'(rcv_valid), 0);
        chk(rcv_tcyc == snd_tcyc + TW'(LAT), "R3", "no loss after drain",
            int'(rcv_tcyc), int'(snd_tcyc) + LAT);
        chk(rcv_k == snd_k + LAT, "R3", "fragments delivered", rcv_k, snd_k + LAT);
    endtask

    initial begin
        t_reset();
        t_preload();
        t_bypass();
        t_idle_payload();
        t_backpressure();
        t_concurrent();
        t_stream();
        t_drain();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        summary();
    end

endmodule